// File: doc/BRIEF.md
# Transmit Descriptor and Byte Count Writer

This block turns a frame request into the memory writes that publish the frame to a transmit engine. A request names one of sixteen transmit rings and carries up to twenty buffer entries, each a 36-bit buffer address and a 12-bit buffer length. The block first checks the request. It then packs a 128-byte descriptor into the ring slot under the ring's write pointer, one 32-bit word per cycle. Next it records the frame's total byte count in that ring's count table. When all writes are done it advances the write pointer.

Each ring has 256 slots. A per-ring read pointer, loaded from outside, frees slots. A ring counts as full at 255 pending descriptors, so a ring can never hold 256. Each count table has 320 halfword entries. The entry for a slot below 64 is written a second time, 256 entries higher, so that a reader can fetch a 64-entry window from any start index without wrapping. All memory traffic leaves on one write port with address, data and byte enables. Fetching the buffers and reading descriptors back are the job of other blocks.

Top module: `txd_writer`

## Requirements
- R1: After reset all write and read pointers are 0, `q_full` is all zero, `req_ready` is 1, and `mem_we` and `done` are 0.
- R2: An accepted, valid request produces 32 full-word writes (`mem_be`=4'hF) on consecutive cycles. They go to DESC_BASE + ring*32768 + slot*128 + 4*w for w = 0 to 31, in ascending order. The slot is the ring's current write pointer.
- R3: The descriptor is laid out little-endian as follows. Bytes 0 to 2 are zero. Byte 3 holds the buffer count in bits 0 to 5, with bits 6 and 7 zero. Buffer entry i starts at byte 4+6i: a 32-bit word holding address bits 31:0, then a 16-bit field with address bits 35:32 in bits 3:0 and the length in bits 15:4. Entries at or beyond the count, and the last 4 bytes, are zero.
- R4: After the descriptor, the sum of the used lengths is written as a 16-bit value to count entry e = slot. The word address is CNT_BASE + ring*1024 + 4*(e/2), with `mem_be`=4'h3 and data in bits 15:0 for even e, or `mem_be`=4'hC and data in bits 31:16 for odd e.
- R5: When the slot is below 64, a second count write follows immediately, to entry slot+256, with the same value and the same lane rule. For slots 64 and above there is no second write.
- R6: One cycle after the last count write, `done` pulses with `done_err`=0 and the ring's write pointer advances by one, modulo 256.
- R7: A request with a buffer count of 0 or above 20 is rejected. `done` pulses with `done_err`=1 on the cycle after acceptance, nothing is written, and the pointer is unchanged.
- R8: A request is also rejected, as in R7, when any used entry has a length of 4092 or more, has address bits 1:0 not zero, or when the used lengths sum to more than 8192. Fields of unused entries are ignored, and a sum of exactly 8192 is accepted.
- R9: `q_full[r]` is 1 exactly when write pointer minus read pointer of ring r equals 255, modulo 256. A request to a full ring is rejected as in R7.
- R10: A pulse on `rd_we` loads `rd_ptr` into the read pointer of ring `rd_queue`. This frees slots, and the full flag reacts in the next cycle.
- R11: `req_ready` is 0 from acceptance of a valid request until its `done`. `req_valid` is ignored while `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Frame request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_queue | input | 4 | Target ring |
| req_nbuf | input | 6 | Number of buffer entries used |
| req_addr | input | 720 | 20 buffer addresses, 36 bits each, entry i at bits 36i+35:36i |
| req_len | input | 240 | 20 buffer lengths, 12 bits each, entry i at bits 12i+11:12i |
| rd_we | input | 1 | Load a read pointer |
| rd_queue | input | 4 | Ring whose read pointer is loaded |
| rd_ptr | input | 8 | New read pointer value |
| q_full | output | 16 | Per-ring full flags |
| done | output | 1 | Request finished (one-cycle pulse) |
| done_err | output | 1 | Request rejected, valid while `done` is 1 |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte enables of the write |
| mem_addr | output | 32 | Byte address of the write, word aligned |
| mem_data | output | 32 | Write data |

## Verification
Two functions can land on the same clock edge. The first is the pointer advance at the end of a frame. The second is a read-pointer load, or the full test that decides whether the next request is accepted. The bench fills one ring to 255 pending descriptors and checks that the flag is set and that the next request is rejected. It then loads that ring's read pointer and sends two more frames. These must land in slot 255 and then in slot 0, the second with its mirrored count write. The bench also holds `req_valid` high with different data during a busy phase. The scoreboard must then see neither an extra write nor a pointer step on the ring named in that stray request.

// File: rtl/txd_pkg.sv
package txd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC,
    ST_CNT,
    ST_MIRR,
    ST_FIN
  } txd_state_e;

  localparam int DESC_BYTES  = 128;
  localparam int HDR_BYTES   = 4;
  localparam int ENT_BYTES   = 6;
  localparam int CNT_STRIDE  = 1024;
  localparam int MIRROR_SPAN = 64;
  localparam int LEN_LIMIT   = 4092;
  localparam int FRAME_LIMIT = 8192;
endpackage

// File: rtl/txd_check.sv
module txd_check
  import txd_pkg::*;
#(
  parameter int NB  = 20,
  parameter int LW  = 12,
  parameter int NBW = 6
) (
  input  logic [NBW-1:0]  nbuf,
  input  logic [NB*2-1:0] align,
  input  logic [NB*LW-1:0] len,
  input  logic            ring_full,
  output logic            bad,
  output logic [15:0]     total
);
  localparam int SW = LW + $clog2(NB + 1);

  logic [NB-1:0] ent_bad;
  logic [SW-1:0] part [NB];
  logic [SW-1:0] acc;

  for (genvar i = 0; i < NB; i++) begin : g_ent
    logic used;
    assign used       = nbuf > NBW'(i);
    assign ent_bad[i] = used && ((len[i*LW +: LW] >= LW'(LEN_LIMIT)) ||
                                 (align[i*2 +: 2] != 2'b00));
    assign part[i]    = used ? SW'(len[i*LW +: LW]) : '0;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NB; i++) acc = acc + part[i];
    total = acc[15:0];
    bad   = (nbuf == '0) || (nbuf > NBW'(NB)) || (|ent_bad) ||
            (acc > SW'(FRAME_LIMIT)) || ring_full;
  end
endmodule

// File: rtl/txd_image.sv
module txd_image
  import txd_pkg::*;
#(
  parameter int NB  = 20,
  parameter int AW  = 36,
  parameter int LW  = 12,
  parameter int NBW = 6,
  parameter int WW  = 5
) (
  input  logic [NBW-1:0]   nbuf,
  input  logic [NB*AW-1:0] addr,
  input  logic [NB*LW-1:0] len,
  input  logic [WW-1:0]    widx,
  output logic [31:0]      word
);
  localparam int IMG_W = DESC_BYTES * 8;

  logic [IMG_W-1:0] img;

  always_comb begin
    img = '0;
    img[8*3 +: 8] = 8'(nbuf);
    for (int i = 0; i < NB; i++) begin
      if (nbuf > NBW'(i)) begin
        img[8*(HDR_BYTES + ENT_BYTES*i) +: 32]      = addr[i*AW +: 32];
        img[8*(HDR_BYTES + ENT_BYTES*i) + 32 +: 16] =
          {len[i*LW +: LW], addr[i*AW + 32 +: AW - 32]};
      end
    end
  end

  assign word = img[{widx, 5'b00000} +: 32];
endmodule

// File: rtl/txd_ptrs.sv
module txd_ptrs #(
  parameter int NQ = 16,
  parameter int QW = 4,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [QW-1:0] adv_q,
  input  logic          rd_we,
  input  logic [QW-1:0] rd_q,
  input  logic [IW-1:0] rd_val,
  input  logic [QW-1:0] sel_q,
  output logic [IW-1:0] sel_wr,
  output logic [NQ-1:0] full
);
  logic [IW-1:0] wr_arr [NQ];

  for (genvar g = 0; g < NQ; g++) begin : g_ring
    logic [IW-1:0] wr_q, rd_q_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        wr_q   <= '0;
        rd_q_r <= '0;
      end else begin
        if (adv && adv_q == QW'(g)) wr_q <= wr_q + 1'b1;
        if (rd_we && rd_q == QW'(g)) rd_q_r <= rd_val;
      end
    end
    assign wr_arr[g] = wr_q;
    assign full[g]   = (wr_q - rd_q_r) == {IW{1'b1}};
  end

  assign sel_wr = wr_arr[sel_q];
endmodule

// File: rtl/txd_writer.sv
module txd_writer
  import txd_pkg::*;
#(
  parameter int          NQ        = 16,
  parameter int          RING      = 256,
  parameter int          NB        = 20,
  parameter int          AW        = 36,
  parameter int          LW        = 12,
  parameter int          MAW       = 32,
  parameter logic [31:0] DESC_BASE = 32'h0010_0000,
  parameter logic [31:0] CNT_BASE  = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [$clog2(NQ)-1:0]   req_queue,
  input  logic [5:0]       req_nbuf,
  input  logic [NB*AW-1:0] req_addr,
  input  logic [NB*LW-1:0] req_len,
  input  logic             rd_we,
  input  logic [$clog2(NQ)-1:0]   rd_queue,
  input  logic [$clog2(RING)-1:0] rd_ptr,
  output logic [NQ-1:0]    q_full,
  output logic             done,
  output logic             done_err,
  output logic             mem_we,
  output logic [3:0]       mem_be,
  output logic [MAW-1:0]   mem_addr,
  output logic [31:0]      mem_data
);
  localparam int QW    = $clog2(NQ);
  localparam int IW    = $clog2(RING);
  localparam int NBW   = 6;
  localparam int WORDS = DESC_BYTES / 4;
  localparam int WW    = $clog2(WORDS);
  localparam int DW    = $clog2(DESC_BYTES);

  txd_state_e        state;
  logic [QW-1:0]     q_r;
  logic [IW-1:0]     idx_r;
  logic [NBW-1:0]    nbuf_r;
  logic [NB*AW-1:0]  addr_r;
  logic [NB*LW-1:0]  len_r;
  logic [15:0]       total_r;
  logic [WW-1:0]     widx_r;

  logic [NB*2-1:0]   align;
  logic              bad;
  logic [15:0]       total;
  logic [IW-1:0]     sel_wr;
  logic [31:0]       word;
  logic              accept;
  logic              adv;
  logic [IW:0]       ent_main, ent_mirr;

  for (genvar i = 0; i < NB; i++) begin : g_align
    assign align[i*2 +: 2] = req_addr[i*AW +: 2];
  end

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign adv       = (state == ST_FIN);
  assign ent_main  = {1'b0, idx_r};
  assign ent_mirr  = ent_main + (IW+1)'(RING);

  txd_check #(.NB(NB), .LW(LW), .NBW(NBW)) u_check (
    .nbuf     (req_nbuf),
    .align    (align),
    .len      (req_len),
    .ring_full(q_full[req_queue]),
    .bad      (bad),
    .total    (total)
  );

  txd_ptrs #(.NQ(NQ), .QW(QW), .IW(IW)) u_ptrs (
    .clk   (clk),
    .rst   (rst),
    .adv   (adv),
    .adv_q (q_r),
    .rd_we (rd_we),
    .rd_q  (rd_queue),
    .rd_val(rd_ptr),
    .sel_q (req_queue),
    .sel_wr(sel_wr),
    .full  (q_full)
  );

  txd_image #(.NB(NB), .AW(AW), .LW(LW), .NBW(NBW), .WW(WW)) u_image (
    .nbuf(nbuf_r),
    .addr(addr_r),
    .len (len_r),
    .widx(widx_r),
    .word(word)
  );

  function automatic logic [MAW-1:0] cnt_addr(input logic [QW-1:0] q,
                                              input logic [IW:0] e);
    return MAW'(CNT_BASE) + MAW'(q) * MAW'(CNT_STRIDE) +
           (MAW'(e >> 1) << 2);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      q_r      <= '0;
      idx_r    <= '0;
      nbuf_r   <= '0;
      addr_r   <= '0;
      len_r    <= '0;
      total_r  <= '0;
      widx_r   <= '0;
      done     <= 1'b0;
      done_err <= 1'b0;
      mem_we   <= 1'b0;
      mem_be   <= '0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_we <= 1'b0;
      done   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (bad) begin
              done     <= 1'b1;
              done_err <= 1'b1;
            end else begin
              q_r     <= req_queue;
              idx_r   <= sel_wr;
              nbuf_r  <= req_nbuf;
              addr_r  <= req_addr;
              len_r   <= req_len;
              total_r <= total;
              widx_r  <= '0;
              state   <= ST_DESC;
            end
          end
        end
        ST_DESC: begin
          mem_we   <= 1'b1;
          mem_be   <= 4'hF;
          mem_addr <= MAW'(DESC_BASE) +
                      (MAW'(q_r) << (IW + DW)) +
                      (MAW'(idx_r) << DW) +
                      (MAW'(widx_r) << 2);
          mem_data <= word;
          widx_r   <= widx_r + 1'b1;
          if (widx_r == WW'(WORDS - 1)) state <= ST_CNT;
        end
        ST_CNT: begin
          mem_we   <= 1'b1;
          mem_be   <= ent_main[0] ? 4'hC : 4'h3;
          mem_addr <= cnt_addr(q_r, ent_main);
          mem_data <= ent_main[0] ? {total_r, 16'h0000} : {16'h0000, total_r};
          state    <= (idx_r < IW'(MIRROR_SPAN)) ? ST_MIRR : ST_FIN;
        end
        ST_MIRR: begin
          mem_we   <= 1'b1;
          mem_be   <= ent_mirr[0] ? 4'hC : 4'h3;
          mem_addr <= cnt_addr(q_r, ent_mirr);
          mem_data <= ent_mirr[0] ? {total_r, 16'h0000} : {16'h0000, total_r};
          state    <= ST_FIN;
        end
        ST_FIN: begin
          done     <= 1'b1;
          done_err <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txd_writer_sva.sv
module txd_writer_sva #(
  parameter int NQ  = 16,
  parameter int MAW = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [$clog2(NQ)-1:0] req_queue,
  input logic [5:0]            req_nbuf,
  input logic [NQ-1:0]         q_full,
  input logic                  done,
  input logic                  done_err,
  input logic                  mem_we,
  input logic [3:0]            mem_be,
  input logic [MAW-1:0]        mem_addr,
  input logic [31:0]           mem_data
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_we && !done && q_full == '0));

  a_r2_word_step: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_be == 4'hF && $past(mem_we) && $past(mem_be) == 4'hF)
      |-> mem_addr == $past(mem_addr) + MAW'(4));

  a_r3_header_bytes: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_be == 4'hF && mem_addr[6:0] == 7'd0)
      |-> (mem_data[23:0] == 24'd0 && mem_data[31:30] == 2'b00));

  a_r4_count_lane: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_be != 4'hF) |-> (mem_be == 4'h3 || mem_be == 4'hC));

  a_r6_done_after_writes: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_we);

  a_r7_bad_count: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_nbuf == 6'd0 || req_nbuf > 6'd20))
      |=> (done && done_err && !mem_we));

  a_r9_full_reject: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && q_full[req_queue]) |=> (done && done_err));

  a_r11_busy_while_writing: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !req_ready);
endmodule

bind txd_writer txd_writer_sva #(.NQ(NQ), .MAW(MAW)) u_sva (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_queue(req_queue),
  .req_nbuf (req_nbuf),
  .q_full   (q_full),
  .done     (done),
  .done_err (done_err),
  .mem_we   (mem_we),
  .mem_be   (mem_be),
  .mem_addr (mem_addr),
  .mem_data (mem_data)
);

// File: tb/txd_writer_test.sv
module txd_writer_test;
  localparam logic [31:0] DB = 32'h0010_0000;
  localparam logic [31:0] CB = 32'h0000_0000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [3:0]   req_queue = '0;
  logic [5:0]   req_nbuf = '0;
  logic [719:0] req_addr = '0;
  logic [239:0] req_len = '0;
  logic         rd_we = 1'b0;
  logic [3:0]   rd_queue = '0;
  logic [7:0]   rd_ptr = '0;
  logic [15:0]  q_full;
  logic         done, done_err, mem_we;
  logic [3:0]   mem_be;
  logic [31:0]  mem_addr, mem_data;

  always #10 clk = ~clk;

  txd_writer uut (.*);

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  be;
    string       tag;
  } wr_t;

  wr_t  exp_wr[$];
  bit   exp_done[$];
  int   total = 0;
  int   bad = 0;
  int   wp[16];
  int   rp[16];
  logic [35:0] ba[20];
  logic [11:0] bl[20];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        if (exp_wr.size() == 0) chk(0, "R11 unexpected write", 64'(mem_addr), 64'hFFFF);
        else begin
          wr_t e;
          e = exp_wr.pop_front();
          chk(mem_addr == e.a && mem_data == e.d && mem_be == e.be, e.tag,
              {mem_addr, mem_data}, {e.a, e.d});
        end
      end
      if (done) begin
        if (exp_done.size() == 0) chk(0, "R11 unexpected done", 64'(done_err), 64'hFF);
        else begin
          bit ee;
          ee = exp_done.pop_front();
          chk(done_err == ee, "R6/R7/R8 done_err", 64'(done_err), 64'(ee));
          chk(exp_wr.size() == 0, "R6 done before last write", 64'(exp_wr.size()), 64'd0);
        end
      end
    end
  end

  function automatic void push_cnt(int q, int e, int tot, string tag);
    wr_t w;
    w.a  = CB + 32'(q * 1024) + 32'((e / 2) * 4);
    w.be = (e % 2) ? 4'hC : 4'h3;
    w.d  = (e % 2) ? {16'(tot), 16'h0} : {16'h0, 16'(tot)};
    w.tag = tag;
    exp_wr.push_back(w);
  endfunction

  task automatic drain();
    int n = 0;
    while ((exp_wr.size() != 0 || exp_done.size() != 0) && n < 300) begin
      @(negedge clk);
      n++;
    end
    if (n >= 300) chk(0, "R6 transaction did not finish", 64'(exp_wr.size()), 64'd0);
    @(negedge clk);
  endtask

  task automatic send(input int q, input int n, input bit linger);
    logic [1023:0] img;
    int tot = 0;
    bit e;
    e = (n == 0) || (n > 20);
    for (int i = 0; i < 20; i++)
      if (i < n) begin
        tot += int'(bl[i]);
        if (bl[i] >= 12'd4092 || ba[i][1:0] != 2'b00) e = 1;
      end
    if (tot > 8192) e = 1;
    if (((wp[q] - rp[q]) & 255) == 255) e = 1;
    if (!e) begin
      int idx = wp[q];
      img = '0;
      img[31:24] = 8'(n);
      for (int i = 0; i < n; i++) begin
        img[32 + 48*i +: 32] = ba[i][31:0];
        img[64 + 48*i +: 16] = {bl[i], ba[i][35:32]};
      end
      for (int w = 0; w < 32; w++) begin
        wr_t x;
        x.a = DB + 32'(q * 32768) + 32'(idx * 128) + 32'(w * 4);
        x.d = img[32*w +: 32];
        x.be = 4'hF;
        x.tag = "R2/R3 descriptor word";
        exp_wr.push_back(x);
      end
      push_cnt(q, idx, tot, "R4 count entry");
      if (idx < 64) push_cnt(q, idx + 256, tot, "R5 mirror entry");
      wp[q] = (wp[q] + 1) % 256;
    end
    exp_done.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_queue = 4'(q);
    req_nbuf  = 6'(n);
    for (int i = 0; i < 20; i++) begin
      req_addr[36*i +: 36] = ba[i];
      req_len[12*i +: 12]  = bl[i];
    end
    req_valid = 1'b1;
    @(negedge clk);
    if (linger && !e) begin
      req_queue = 4'd9;
      req_nbuf  = 6'd1;
      for (int k = 0; k < 10; k++) begin
        chk(req_ready == 1'b0, "R11 ready low while busy", 64'(req_ready), 64'd0);
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    drain();
  endtask

  task automatic fill(input int seed, input int len);
    for (int i = 0; i < 20; i++) begin
      ba[i] = {4'(seed + i), 32'(seed * 32'h01010101 + i * 32'h0001_0040)} & ~36'h3;
      bl[i] = 12'(len + i);
    end
  endtask

  task automatic setrd(input int q, input int v);
    @(negedge clk);
    rd_queue = 4'(q);
    rd_ptr = 8'(v);
    rd_we = 1'b1;
    @(negedge clk);
    rd_we = 1'b0;
    rp[q] = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 64'd0, 64'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin wp[i] = 0; rp[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(q_full == 16'h0, "R1 full flags", 64'(q_full), 64'd0);
    chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    chk(!mem_we && !done, "R1 quiet", 64'({mem_we, done}), 64'd0);

    // R2 R3 R4 R5 basic frames
    fill(3, 100);
    send(3, 3, 0);
    fill(7, 350);
    send(3, 20, 0);                    // odd slot, 20 entries, total 7190
    fill(11, 60);
    send(0, 1, 0);

    // R7 bad counts
    send(4, 0, 0);
    send(4, 21, 0);
    // R8 length and alignment limits
    fill(5, 4091); bl[0] = 12'd4092; send(4, 1, 0);
    fill(5, 4091); bl[0] = 12'd4091; send(4, 1, 0);
    fill(6, 10); ba[1][1:0] = 2'b10; send(4, 2, 0);
    fill(6, 4000); bl[0] = 12'd4000; bl[1] = 12'd4000; bl[2] = 12'd400; send(4, 3, 0);
    fill(6, 10); bl[0] = 12'd4091; bl[1] = 12'd4091; bl[2] = 12'd10; send(4, 3, 0);
    fill(8, 40); bl[5] = 12'hFFF; ba[6][1:0] = 2'b01; send(4, 2, 0); // R8 unused ignored

    // R11 stray request while busy, then ring 9 must still use slot 0
    fill(9, 33);
    send(2, 4, 1);
    send(9, 2, 0);

    // R5 mirror boundary: slots 0..65 on ring 5
    for (int k = 0; k < 66; k++) begin
      fill(k, 20 + k);
      send(5, 1 + (k % 20), 0);
    end

    // R9 R10 fill ring 7
    for (int k = 0; k < 254; k++) begin
      fill(k + 100, 8);
      send(7, 1, 0);
    end
    chk(q_full[7] == 1'b0, "R9 not full at 254", 64'(q_full), 64'd0);
    fill(1, 8);
    send(7, 1, 0);
    chk(q_full[7] == 1'b1, "R9 full at 255", 64'(q_full[7]), 64'd1);
    chk(q_full[6:0] == 7'd0 && q_full[15:8] == 8'd0, "R9 other rings", 64'(q_full), 64'h80);
    fill(2, 8);
    send(7, 1, 0);                     // rejected, ring full
    setrd(7, 10);
    chk(q_full[7] == 1'b0, "R10 freed after read pointer load", 64'(q_full[7]), 64'd0);
    fill(3, 12);
    send(7, 2, 0);                     // slot 255
    fill(4, 13);
    send(7, 2, 0);                     // wraps to slot 0, mirrored

    repeat (5) @(negedge clk);
    chk(exp_wr.size() == 0 && exp_done.size() == 0, "R6 scoreboard empty",
        64'(exp_wr.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule